// File: doc/BRIEF.md
# Clock-Synthesizer Control Register Bank

This block is the register bank that a host uses to program a clock-synthesis loop and to watch it settle. It stores the divider and configuration words, plus two words for spread-spectrum settings that have no effect here. It takes a commit strobe that applies the stored configuration, and it presents a status word. The status word reports whether the block has come out of reset, whether the loop is locked, whether an apply is still running, whether the reference is missing, whether the output is bypassed, and whether each of four divider outputs has acknowledged its enable.

The analog loop is replaced by a timer. A commit loads the timer from a delay field in the control word. The loop reads as unlocked while the timer runs and as locked when it expires. The host side is a valid/ready request port: writes take effect at the accepting edge, and read data returns with a response strobe one cycle after the request is accepted. Every cycle in this block is a reference cycle.

Top module: `pllc_regbank`

## Requirements
- R1: `req_ready` is always 1. A read accepted at one edge returns its data with `rsp_valid` high during the next cycle only. The seven storage words read back all 32 bits exactly as written: control 0x00, config1 0x0C, config2 0x10, config3 0x14, spread words 0x18 and 0x1C, and config4 0x20.
- R2: A read of any offset that is not a defined word-aligned offset returns 0, and a write to such an offset changes nothing. A write to status (0x04) changes nothing.
- R3: Status bit 0 (reset done) is 0 for the first 16 clock edges after reset is released and is 1 from the 16th such edge onward.
- R4: Writing 1 to bit 0 of the commit word (0x08) starts an apply. Bit 0 of 0x08 and status bit 2 (recalibrating) read 1 until the apply ends, and then clear by themselves. A write to 0x08 with bit 0 clear has no effect.
- R5: Let D be control bits [15:0], with 0 taken as 1. Status bit 1 (lock) sets, and the apply ends, exactly D edges after the edge that accepted the commit write.
- R6: A commit written while lock is 1 clears lock at the accepting edge. Lock then sets again after the delay in R5.
- R7: Status bit 3 (loss of reference) is the inverse of config2 bit 13 (reference enable). Status bit 6 (bypass) is the inverse of lock. Status bits 4, 5, 9 and 12 to 31 are always 0.
- R8: Divider outputs 0 to 3 have enables at config2 bits 16, 18, 23 and 25, and acknowledges at status bits 7, 8, 10 and 11. An acknowledge is 1 one edge after its enable is 1 while config2 bit 20 (divider bypass) is 0. It drops one edge after either condition stops holding.
- R9: After reset done, with the reference enabled and an apply completed, status masked with 0x6F equals 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference/bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
The hardest part to reach from the ports is the exact edge on which lock returns after a commit. From the bus, that edge can only be seen by reading status on every edge after the commit. The stimulus therefore issues back-to-back status reads right after the commit write. It expects the lock bit to change on a single read, computed from the programmed delay, the zero-delay case included. The 16-edge reset-done window is pinned the same way, with an unbroken run of status reads that starts at reset release. Acknowledge set and drop are likewise caught by two reads issued directly after each config2 write.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned NUM_DIV = 4;
    localparam int unsigned NSTORE  = 7;

    localparam int unsigned CFG2_REFEN  = 13;
    localparam int unsigned CFG2_DIVBYP = 20;

    // storage words first so that the selector doubles as array index
    typedef enum logic [3:0] {
        SEL_CTRL = 4'd0,
        SEL_CFG1 = 4'd1,
        SEL_CFG2 = 4'd2,
        SEL_CFG3 = 4'd3,
        SEL_SSC1 = 4'd4,
        SEL_SSC2 = 4'd5,
        SEL_CFG4 = 4'd6,
        SEL_STAT = 4'd7,
        SEL_GO   = 4'd8,
        SEL_NONE = 4'd9
    } reg_sel_e;

    typedef struct packed {
        logic               rst_done;
        logic               lock;
        logic               recal;
        logic               lossref;
        logic               hijit;
        logic               bypass;
        logic [NUM_DIV-1:0] ack;
    } pll_stat_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] off);
        case (off)
            8'h00:   return SEL_CTRL;
            8'h04:   return SEL_STAT;
            8'h08:   return SEL_GO;
            8'h0C:   return SEL_CFG1;
            8'h10:   return SEL_CFG2;
            8'h14:   return SEL_CFG3;
            8'h18:   return SEL_SSC1;
            8'h1C:   return SEL_SSC2;
            8'h20:   return SEL_CFG4;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic int unsigned div_en_bit(input int unsigned i);
        case (i)
            0:       return 16;
            1:       return 18;
            2:       return 23;
            default: return 25;
        endcase
    endfunction

    function automatic int unsigned div_ack_bit(input int unsigned i);
        case (i)
            0:       return 7;
            1:       return 8;
            2:       return 10;
            default: return 11;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input pll_stat_t s);
        logic [WORD_W-1:0] w;
        w    = '0;
        w[0] = s.rst_done;
        w[1] = s.lock;
        w[2] = s.recal;
        w[3] = s.lossref;
        w[5] = s.hijit;
        w[6] = s.bypass;
        for (int i = 0; i < NUM_DIV; i++) begin
            w[div_ack_bit(i)] = s.ack[i];
        end
        return w;
    endfunction

endpackage

// File: rtl/pllc_regfile.sv
module pllc_regfile
    import pllc_pkg::*;
#(
    parameter int unsigned TMR_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [WORD_W-1:0]   req_wdata,
    input  logic [WORD_W-1:0]   status_word,
    input  logic                go_busy,
    output logic                go_start,
    output logic [TMR_W-1:0]    lock_delay,
    output logic                ref_en,
    output logic                div_byp,
    output logic [NUM_DIV-1:0]  div_en,
    output logic                rsp_valid,
    output logic [WORD_W-1:0]   rsp_rdata
);

    reg_sel_e          sel;
    logic              wr_fire;
    logic              rd_fire;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] store [NSTORE];

    assign sel     = decode_offset(req_addr);
    assign wr_fire = req_valid &&  req_write;
    assign rd_fire = req_valid && !req_write;

    genvar g;
    generate
        for (g = 0; g < NSTORE; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    store[g] <= '0;
                end else if (wr_fire && sel == reg_sel_e'(g)) begin
                    store[g] <= req_wdata;
                end
            end
        end
        for (g = 0; g < NUM_DIV; g++) begin : g_en
            assign div_en[g] = store[SEL_CFG2][div_en_bit(g)];
        end
    endgenerate

    assign go_start   = wr_fire && (sel == SEL_GO) && req_wdata[0];
    assign lock_delay = store[SEL_CTRL][TMR_W-1:0];
    assign ref_en     = store[SEL_CFG2][CFG2_REFEN];
    assign div_byp    = store[SEL_CFG2][CFG2_DIVBYP];

    always_comb begin
        case (sel)
            SEL_CTRL: rd_mux = store[0];
            SEL_CFG1: rd_mux = store[1];
            SEL_CFG2: rd_mux = store[2];
            SEL_CFG3: rd_mux = store[3];
            SEL_SSC1: rd_mux = store[4];
            SEL_SSC2: rd_mux = store[5];
            SEL_CFG4: rd_mux = store[6];
            SEL_STAT: rd_mux = status_word;
            SEL_GO:   rd_mux = {{(WORD_W-1){1'b0}}, go_busy};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_fire;
            rsp_rdata <= rd_fire ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/pllc_lock_model.sv
module pllc_lock_model #(
    parameter int unsigned TMR_W        = 16,
    parameter int unsigned RST_DONE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_start,
    input  logic [TMR_W-1:0] lock_delay,
    output logic             rst_done,
    output logic             lock,
    output logic             busy
);

    localparam int unsigned CNT_W = $clog2(RST_DONE_CYC + 1);

    logic [CNT_W-1:0] rd_cnt;
    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_cnt   <= '0;
            rst_done <= 1'b0;
        end else if (!rst_done) begin
            rd_cnt <= rd_cnt + 1'b1;
            if (rd_cnt == CNT_W'(RST_DONE_CYC - 1)) begin
                rst_done <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            lock <= 1'b0;
            tmr  <= '0;
        end else if (go_start) begin
            busy <= 1'b1;
            lock <= 1'b0;
            tmr  <= (lock_delay == '0) ? '0 : lock_delay - 1'b1;
        end else if (busy) begin
            if (tmr == '0) begin
                busy <= 1'b0;
                lock <= 1'b1;
            end else begin
                tmr <= tmr - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pllc_div_ack.sv
module pllc_div_ack
    import pllc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_DIV-1:0] div_en,
    input  logic               div_byp,
    output logic [NUM_DIV-1:0] ack
);

    genvar g;
    generate
        for (g = 0; g < NUM_DIV; g++) begin : g_ack
            always_ff @(posedge clk) begin
                if (rst) begin
                    ack[g] <= 1'b0;
                end else begin
                    ack[g] <= div_en[g] && !div_byp;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pllc_regbank.sv
module pllc_regbank
    import pllc_pkg::*;
#(
    parameter int unsigned TMR_W        = 16,
    parameter int unsigned RST_DONE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);

    logic               go_start;
    logic [TMR_W-1:0]   lock_delay;
    logic               ref_en;
    logic               div_byp;
    logic [NUM_DIV-1:0] div_en;
    logic [NUM_DIV-1:0] div_ack;
    logic               rst_done;
    logic               lock_q;
    logic               busy_q;
    pll_stat_t          stat;
    logic [WORD_W-1:0]  status_word;

    assign req_ready = 1'b1;

    always_comb begin
        stat.rst_done = rst_done;
        stat.lock     = lock_q;
        stat.recal    = busy_q;
        stat.lossref  = !ref_en;
        stat.hijit    = 1'b0;
        stat.bypass   = !lock_q;
        stat.ack      = div_ack;
    end

    assign status_word = pack_status(stat);

    pllc_regfile #(.TMR_W(TMR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .status_word (status_word),
        .go_busy     (busy_q),
        .go_start    (go_start),
        .lock_delay  (lock_delay),
        .ref_en      (ref_en),
        .div_byp     (div_byp),
        .div_en      (div_en),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

    pllc_lock_model #(.TMR_W(TMR_W), .RST_DONE_CYC(RST_DONE_CYC)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .go_start   (go_start),
        .lock_delay (lock_delay),
        .rst_done   (rst_done),
        .lock       (lock_q),
        .busy       (busy_q)
    );

    pllc_div_ack u_ack (
        .clk     (clk),
        .rst     (rst),
        .div_en  (div_en),
        .div_byp (div_byp),
        .ack     (div_ack)
    );

endmodule

// File: rtl/pllc_regbank_chk.sv
module pllc_regbank_chk
    import pllc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [7:0]         req_addr,
    input logic [31:0]        req_wdata,
    input logic               rsp_valid,
    input logic               rst_done,
    input logic               lock_q,
    input logic               busy_q,
    input logic [NUM_DIV-1:0] div_en,
    input logic               div_byp,
    input logic [NUM_DIV-1:0] div_ack
);

    // R1
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    // R3
    rst_done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rst_done |=> rst_done);

    // R5
    lock_after_apply_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> ($past(busy_q) && !busy_q));

    // R6
    go_drops_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == 8'h08 && req_wdata[0])
        |=> (!lock_q && busy_q));

    genvar g;
    generate
        for (g = 0; g < NUM_DIV; g++) begin : g_chk
            // R8
            ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
                div_ack[g] == $past(div_en[g] && !div_byp));
        end
    endgenerate

endmodule

bind pllc_regbank pllc_regbank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rst_done  (rst_done),
    .lock_q    (lock_q),
    .busy_q    (busy_q),
    .div_en    (div_en),
    .div_byp   (div_byp),
    .div_ack   (div_ack)
);

// File: tb/pllc_regbank_tb.sv
module pllc_regbank_tb;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pllc_regbank u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: pops one expected word per response
    always @(negedge clk) begin
        if (!rst) begin
            check("R1 ready", {31'b0, req_ready}, 32'd1);
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected response", 32'd1, 32'd0);
                end else begin
                    check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        rst = 1'b0;
        // R3: reads on edges 1..16 see reset done low, edge 17 sees it high
        for (int i = 1; i <= 16; i++) do_read(8'h04, 32'h48, "R3 before done");
        do_read(8'h04, 32'h49, "R3 after done");

        // R1 storage readback
        do_write(8'h00, 32'hABCD0005);
        do_write(8'h0C, 32'h12345678);
        do_write(8'h14, 32'h0F0F1234);
        do_write(8'h18, 32'hDEADBEEF);
        do_write(8'h1C, 32'h01020304);
        do_write(8'h20, 32'h01FC0003);
        do_read(8'h00, 32'hABCD0005, "R1 ctrl");
        do_read(8'h0C, 32'h12345678, "R1 cfg1");
        do_read(8'h14, 32'h0F0F1234, "R1 cfg3");
        do_read(8'h18, 32'hDEADBEEF, "R1 ssc1");
        do_read(8'h1C, 32'h01020304, "R1 ssc2");
        do_read(8'h20, 32'h01FC0003, "R1 cfg4");

        // R2 undefined offsets and read-only status
        do_write(8'h24, 32'hFFFFFFFF);
        do_write(8'h0D, 32'h00000000);
        do_write(8'h04, 32'hFFFFFFFF);
        do_read(8'h24, 32'h0, "R2 undefined 0x24");
        do_read(8'h3C, 32'h0, "R2 undefined 0x3C");
        do_read(8'h02, 32'h0, "R2 misaligned 0x02");
        do_read(8'h0C, 32'h12345678, "R2 misaligned write ignored");
        do_read(8'h04, 32'h49, "R2 status write ignored");

        // R4 commit with bit 0 clear does nothing
        do_write(8'h08, 32'hFFFFFFFE);
        do_read(8'h08, 32'h0, "R4 go bit0 clear");
        do_read(8'h04, 32'h49, "R4 no apply started");

        // R7 reference enable clears loss of reference
        do_write(8'h10, 32'h00002000);
        do_read(8'h10, 32'h00002000, "R1 cfg2");
        do_read(8'h04, 32'h41, "R7 refen");

        // R5 delay 5: reads 1..5 busy, read 6 locked
        do_write(8'h08, 32'h1);
        for (int j = 1; j <= 5; j++) do_read(8'h04, 32'h45, "R5 applying");
        do_read(8'h04, 32'h03, "R5 R9 locked");
        do_read(8'h08, 32'h0, "R4 go self clear");

        // R8 acknowledges
        do_write(8'h10, 32'h00812000);
        do_read(8'h04, 32'h003, "R8 ack not yet");
        do_read(8'h04, 32'h483, "R8 ack set");
        do_write(8'h10, 32'h00912000);
        do_read(8'h04, 32'h483, "R8 bypass not yet");
        do_read(8'h04, 32'h003, "R8 bypass drops ack");
        do_write(8'h10, 32'h02852000);
        do_read(8'h04, 32'h003, "R8 all not yet");
        do_read(8'h04, 32'hD83, "R8 all acks");

        // R6 commit while locked, zero delay treated as one
        do_write(8'h00, 32'h0);
        do_write(8'h08, 32'h1);
        do_read(8'h04, 32'hDC5, "R6 lock dropped");
        do_read(8'h04, 32'hD83, "R5 zero delay relock");

        // R4 busy readback with delay 3
        do_write(8'h00, 32'h3);
        do_write(8'h08, 32'h1);
        do_read(8'h08, 32'h1, "R4 busy 1");
        do_read(8'h08, 32'h1, "R4 busy 2");
        do_read(8'h08, 32'h1, "R4 busy 3");
        do_read(8'h08, 32'h0, "R4 busy cleared");
        do_read(8'h04, 32'hD83, "R9 locked word");

        repeat (3) @(negedge clk);
        check("R1 all responses seen", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule